// File: doc/BRIEF.md
# Device-Side Command Mailbox Register Block

This block is the device end of a command mailbox. A host reaches it through a plain register port. The host places an opcode and an input length in a command register and fills a payload window. It then sets a doorbell bit to hand the command to the device. The device logic sees a one-cycle launch strobe together with the opcode and length. It reads and writes the payload RAM through its own port, and it ends the command with a completion strobe that carries a return code, an output length and a flag that moves the work into the background. The doorbell then drops, and every result stays frozen until the host rings the doorbell again.

A command that finishes in the background reports a dedicated return code in the status register and starts a separate progress record. That record holds the opcode, a percentage and a final return code. The device feeds percentage updates to this record. When the percentage reaches 100, the final return code is latched. If the host has enabled it, the block then gives a one-cycle interrupt pulse. A capability register tells the host the payload size as a power-of-two exponent, whether the interrupt exists, and which message number it uses.

Top module: `cmd_mailbox_dev`

## Requirements
- R1: After reset, the control (0x08), command (0x10), status (0x18) and background (0x20) registers all read 0. dev_cmd_valid and irq_pulse are low, and a percentage update with no background command running leaves the background register at 0.
- R2: The capability register at 0x00 reads bits [4:0] = payload size exponent (default 8, i.e. 256 bytes), bit 5 = interrupt supported, bits [15:8] = interrupt message number (default 3), and all other bits 0.
- R3: A host write to control with bit 0 set while idle rings the doorbell. After that clock edge, dev_cmd_valid is high for exactly one cycle, and dev_opcode and dev_in_len show command register bits [15:0] and [36:16].
- R4: While the doorbell is set, control bit 0 reads 1, and further doorbell writes produce no extra launch strobe.
- R5: A completion (dev_done) while busy clears the doorbell. It loads status bits [15:0] with dev_rc and command bits [36:16] with dev_out_len, and keeps the opcode. A completion while idle changes nothing.
- R6: While the doorbell is set, host writes to the command register and the payload window are dropped. While idle, device payload writes are dropped.
- R7: The payload window starts at byte 0x800 and holds 32-bit words at byte offset 4·i. The host and the device (word index i) see the same storage. Host reads inside 0x800–0xFFF but beyond the payload size return 0.
- R8: A completion with dev_bg set writes 0x0001 to status bits [15:0]. It loads the background register with opcode [15:0] = command opcode, percentage [22:16] = 0 and final code [47:32] = 0.
- R9: Percentage updates are taken only while a background command runs, and values above 100 are stored as 100. On reaching 100, dev_bg_rc is latched into bits [47:32] and later updates are ignored.
- R10: When the percentage reaches 100 and control bit 1 (interrupt enable, as held before that cycle's writes) is set, irq_pulse is high for exactly one cycle. It stays low when the bit is clear.
- R11: A doorbell write that falls in the same cycle as a completion is ignored: the command completes and the doorbell reads clear afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, one cycle after host_rd |
| host_rvalid | output | 1 | Read data valid |
| dev_cmd_valid | output | 1 | One-cycle command launch strobe |
| dev_opcode | output | 16 | Opcode of the current command |
| dev_in_len | output | 21 | Length field of the command register |
| dev_pl_wr | input | 1 | Device payload write strobe |
| dev_pl_rd | input | 1 | Device payload read strobe |
| dev_pl_idx | input | PAY_EXP-2 | Device payload word index |
| dev_pl_wdata | input | 32 | Device payload write data |
| dev_pl_rdata | output | 32 | Device payload read data, one cycle after dev_pl_rd |
| dev_done | input | 1 | Command completion strobe |
| dev_rc | input | 16 | Completion return code |
| dev_out_len | input | 21 | Output payload length |
| dev_bg | input | 1 | Completion continues in the background |
| dev_pct_valid | input | 1 | Percentage update strobe |
| dev_pct | input | 7 | Percentage complete |
| dev_bg_rc | input | 16 | Final background return code |
| irq_pulse | output | 1 | Background completion interrupt pulse |

## Verification
Two pairs of events can land in one cycle. The first pair is a doorbell write and a completion. The bench drives both strobes in the same cycle and then expects no second launch strobe and a clear doorbell. The second pair is a write to the interrupt-enable bit and the percentage reaching 100. The bench drives these together in both directions, enabling and disabling. It expects the pulse to follow the enable value held before that cycle, so disabling in the same cycle still pulses and enabling does not. Payload storage and progress values are swept over their full range, and the expected words and percentages are computed in the bench.

// File: rtl/mbx_pkg.sv
// Package: shared widths, return codes and register offsets for the
// command mailbox. Assumes 64-bit host registers on 8-byte offsets.
package mbx_pkg;
    localparam int OPC_W = 16;
    localparam int LEN_W = 21;
    localparam int RC_W  = 16;
    localparam int PCT_W = 7;

    typedef logic [OPC_W-1:0] opc_t;
    typedef logic [LEN_W-1:0] len_t;
    typedef logic [RC_W-1:0]  rc_t;
    typedef logic [PCT_W-1:0] pct_t;

    localparam rc_t  RC_BACKGROUND = 16'h0001;
    localparam pct_t PCT_DONE      = 7'd100;

    localparam logic [7:0] OFS_CAP  = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_CMD  = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h18;
    localparam logic [7:0] OFS_BG   = 8'h20;
endpackage

// File: rtl/mbx_payload_ram.sv
// Payload RAM: word storage shared by the host and the device.
// Assumes the caller gates writers so that only one side writes at a time
// (host while idle, device while busy); the device port wins if both fire.
// Reads are combinational; the top registers them.
module mbx_payload_ram #(
    parameter int WORDS = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata_c,
    input  logic             dev_we,
    input  logic [IDX_W-1:0] dev_idx,
    input  logic [31:0]      dev_wdata,
    output logic [31:0]      dev_rdata_c
);
    logic [31:0] mem [WORDS];

    // Write port: device first, host otherwise.
    always_ff @(posedge clk) begin
        if (dev_we) begin
            mem[dev_idx] <= dev_wdata;
        end else if (host_we) begin
            mem[host_idx] <= host_wdata;
        end
    end

    // Read ports: plain array lookups.
    assign host_rdata_c = mem[host_idx];
    assign dev_rdata_c  = mem[dev_idx];

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && dev_we)); // R6
endmodule

// File: rtl/mbx_core.sv
// Doorbell core: holds the doorbell, interrupt enable, command and status.
// Assumes cmd_wr is already gated to idle periods by the caller. A launch
// is only possible while idle; a completion is only taken while busy.
module mbx_core
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_wdata,
    input  logic       cmd_wr,
    input  opc_t       cmd_opc_in,
    input  len_t       cmd_len_in,
    input  logic       dev_done,
    input  rc_t        dev_rc,
    input  len_t       dev_out_len,
    input  logic       dev_bg,
    output logic       busy,
    output logic       irq_en,
    output opc_t       opcode,
    output len_t       len,
    output rc_t        rc,
    output logic       cmd_valid,
    output logic       bg_launch
);
    // Background hand-off happens in the completion cycle itself.
    assign bg_launch = busy && dev_done && dev_bg;

    // Interrupt enable follows every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (ctrl_wr) begin
            irq_en <= ctrl_wdata[1];
        end
    end

    // Doorbell handshake, command capture and result loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cmd_valid <= 1'b0;
            opcode    <= '0;
            len       <= '0;
            rc        <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (busy) begin
                if (dev_done) begin
                    busy <= 1'b0;
                    len  <= dev_out_len;
                    rc   <= dev_bg ? RC_BACKGROUND : dev_rc;
                end
            end else begin
                if (cmd_wr) begin
                    opcode <= cmd_opc_in;
                    len    <= cmd_len_in;
                end
                if (ctrl_wr && ctrl_wdata[0]) begin
                    busy      <= 1'b1;
                    cmd_valid <= 1'b1;
                end
            end
        end
    end

    AST_DB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !dev_done |=> busy); // R4
    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !dev_done |=> $stable(opcode) && $stable(len)); // R6
    AST_IDLE_RC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rc)); // R5
    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R3
    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy); // R3
endmodule

// File: rtl/mbx_bg_tracker.sv
// Background tracker: opcode, percentage and final code of a command that
// continues after its doorbell has cleared. Assumes launch comes from the
// core's completion path; a launch in the same cycle as an update wins.
module mbx_bg_tracker
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  opc_t launch_opc,
    input  logic pct_valid,
    input  pct_t pct_in,
    input  rc_t  final_rc,
    input  logic irq_en,
    output opc_t bg_opc,
    output pct_t bg_pct,
    output rc_t  bg_rc,
    output logic active,
    output logic done_pulse
);
    pct_t pct_clamped;

    // Values above 100 saturate to 100.
    assign pct_clamped = (pct_in > PCT_DONE) ? PCT_DONE : pct_in;

    // Progress record and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bg_opc     <= '0;
            bg_pct     <= '0;
            bg_rc      <= '0;
            active     <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (launch) begin
                bg_opc <= launch_opc;
                bg_pct <= '0;
                bg_rc  <= '0;
                active <= 1'b1;
            end else if (active && pct_valid) begin
                bg_pct <= pct_clamped;
                if (pct_clamped == PCT_DONE) begin
                    bg_rc      <= final_rc;
                    active     <= 1'b0;
                    done_pulse <= irq_en;
                end
            end
        end
    end

    AST_PCT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bg_pct <= PCT_DONE); // R9
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R10
    AST_BG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !launch |=> $stable(bg_pct) && $stable(bg_rc)); // R9
endmodule

// File: rtl/cmd_mailbox_dev.sv
// Top: host register decode, read mux and device-side ports of the command
// mailbox. Assumes single-cycle host accesses; reads return next cycle.
// The payload window sits in the upper half of the host address space.
module cmd_mailbox_dev
    import mbx_pkg::*;
#(
    parameter int         ADDR_W      = 12,
    parameter int         PAY_EXP     = 8,
    parameter bit         IRQ_CAP     = 1'b1,
    parameter logic [7:0] IRQ_MSG_NUM = 8'd3,
    localparam int        IDX_W       = PAY_EXP - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [63:0]       host_wdata,
    output logic [63:0]       host_rdata,
    output logic              host_rvalid,
    output logic              dev_cmd_valid,
    output logic [15:0]       dev_opcode,
    output logic [20:0]       dev_in_len,
    input  logic              dev_pl_wr,
    input  logic              dev_pl_rd,
    input  logic [IDX_W-1:0]  dev_pl_idx,
    input  logic [31:0]       dev_pl_wdata,
    output logic [31:0]       dev_pl_rdata,
    input  logic              dev_done,
    input  logic [15:0]       dev_rc,
    input  logic [20:0]       dev_out_len,
    input  logic              dev_bg,
    input  logic              dev_pct_valid,
    input  logic [6:0]        dev_pct,
    input  logic [15:0]       dev_bg_rc,
    output logic              irq_pulse
);
    localparam int                WORDS    = (1 << PAY_EXP) / 4;
    localparam int                PL_BYTES = 1 << PAY_EXP;
    localparam logic [ADDR_W-2:0] PL_LIMIT = (ADDR_W-1)'(PL_BYTES);
    localparam logic [ADDR_W-1:0] A_CAP    = ADDR_W'(OFS_CAP);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_BG     = ADDR_W'(OFS_BG);
    localparam logic [63:0]       CAP_WORD =
        {48'd0, IRQ_MSG_NUM, 2'b00, IRQ_CAP, 5'(PAY_EXP)};

    logic             busy, irq_en, bg_launch, bg_active, bg_pulse;
    logic             in_window, ctrl_wr, cmd_wr, pl_host_we, pl_dev_we;
    opc_t             opcode, bg_opc;
    len_t             len;
    rc_t              rc, bg_rc;
    pct_t             bg_pct;
    logic [IDX_W-1:0] host_idx;
    logic [31:0]      host_word, dev_word;
    logic [63:0]      rd_mux;
    logic             unused_bits;

    assign unused_bits = ^{host_wdata[63:37], bg_active};

    // Host address decode and write gating.
    assign in_window  = host_addr[ADDR_W-1] && (host_addr[ADDR_W-2:0] < PL_LIMIT);
    assign host_idx   = host_addr[PAY_EXP-1:2];
    assign ctrl_wr    = host_wr && (host_addr == A_CTRL);
    assign cmd_wr     = host_wr && (host_addr == A_CMD) && !busy;
    assign pl_host_we = host_wr && in_window && !busy;
    assign pl_dev_we  = dev_pl_wr && busy;

    mbx_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_wdata  (host_wdata[1:0]),
        .cmd_wr      (cmd_wr),
        .cmd_opc_in  (host_wdata[15:0]),
        .cmd_len_in  (host_wdata[36:16]),
        .dev_done    (dev_done),
        .dev_rc      (dev_rc),
        .dev_out_len (dev_out_len),
        .dev_bg      (dev_bg),
        .busy        (busy),
        .irq_en      (irq_en),
        .opcode      (opcode),
        .len         (len),
        .rc          (rc),
        .cmd_valid   (dev_cmd_valid),
        .bg_launch   (bg_launch)
    );

    mbx_bg_tracker u_bg (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (bg_launch),
        .launch_opc (opcode),
        .pct_valid  (dev_pct_valid),
        .pct_in     (dev_pct),
        .final_rc   (dev_bg_rc),
        .irq_en     (irq_en),
        .bg_opc     (bg_opc),
        .bg_pct     (bg_pct),
        .bg_rc      (bg_rc),
        .active     (bg_active),
        .done_pulse (bg_pulse)
    );

    mbx_payload_ram #(.WORDS(WORDS), .IDX_W(IDX_W)) u_ram (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we      (pl_host_we),
        .host_idx     (host_idx),
        .host_wdata   (host_wdata[31:0]),
        .host_rdata_c (host_word),
        .dev_we       (pl_dev_we),
        .dev_idx      (dev_pl_idx),
        .dev_wdata    (dev_pl_wdata),
        .dev_rdata_c  (dev_word)
    );

    // Interrupt output exists only when the capability is built in.
    generate
        if (IRQ_CAP) begin : g_irq
            assign irq_pulse = bg_pulse;
        end else begin : g_no_irq
            logic unused_pulse;
            assign unused_pulse = bg_pulse;
            assign irq_pulse    = 1'b0;
        end
    endgenerate

    assign dev_opcode = opcode;
    assign dev_in_len = len;

    // Host read mux over registers and the payload window.
    always_comb begin
        case (host_addr)
            A_CAP:   rd_mux = CAP_WORD;
            A_CTRL:  rd_mux = {62'd0, irq_en, busy};
            A_CMD:   rd_mux = {27'd0, len, opcode};
            A_STAT:  rd_mux = {48'd0, rc};
            A_BG:    rd_mux = {16'd0, bg_rc, 9'd0, bg_pct, bg_opc};
            default: rd_mux = in_window ? {32'd0, host_word} : 64'd0;
        endcase
    end

    // Registered host read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) begin
                host_rdata <= rd_mux;
            end
        end
    end

    // Registered device payload read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_pl_rdata <= '0;
        end else if (dev_pl_rd) begin
            dev_pl_rdata <= dev_word;
        end
    end

    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid); // R7
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq_pulse); // R10
endmodule

// File: tb/sim_cmd_mailbox_dev.sv
// Bench for cmd_mailbox_dev: sweeps payload words and percentages and
// provokes same-cycle doorbell/completion and enable/finish collisions.
module sim_cmd_mailbox_dev;
    localparam int ADDR_W = 12;
    localparam logic [11:0] A_CAP  = 12'h000;
    localparam logic [11:0] A_CTRL = 12'h008;
    localparam logic [11:0] A_CMD  = 12'h010;
    localparam logic [11:0] A_STAT = 12'h018;
    localparam logic [11:0] A_BG   = 12'h020;
    localparam logic [11:0] A_PL   = 12'h800;
    localparam int NWORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 0, host_rd = 0;
    logic [11:0] host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        host_rvalid;
    logic        dev_cmd_valid;
    logic [15:0] dev_opcode;
    logic [20:0] dev_in_len;
    logic        dev_pl_wr = 0, dev_pl_rd = 0;
    logic [5:0]  dev_pl_idx = '0;
    logic [31:0] dev_pl_wdata = '0;
    logic [31:0] dev_pl_rdata;
    logic        dev_done = 0;
    logic [15:0] dev_rc = '0;
    logic [20:0] dev_out_len = '0;
    logic        dev_bg = 0;
    logic        dev_pct_valid = 0;
    logic [6:0]  dev_pct = '0;
    logic [15:0] dev_bg_rc = '0;
    logic        irq_pulse;

    int n_chk = 0, n_fail = 0, launches = 0;
    logic [63:0] rv;

    always #2 clk = ~clk;

    cmd_mailbox_dev #(.ADDR_W(ADDR_W)) u0 (.*);

    always @(negedge clk) if (dev_cmd_valid) launches++;

    function automatic logic [31:0] pat_h(int i);
        return 32'hC3A50000 + 32'(i) * 32'h00010103;
    endfunction
    function automatic logic [31:0] pat_d(int i);
        return ~pat_h(i) ^ 32'(i);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask
    task automatic hrd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk); host_rd = 1; host_addr = a;
        @(negedge clk); host_rd = 0; d = host_rdata;
    endtask
    task automatic dwr(input int i, input logic [31:0] d);
        @(negedge clk); dev_pl_wr = 1; dev_pl_idx = 6'(i); dev_pl_wdata = d;
        @(negedge clk); dev_pl_wr = 0;
    endtask
    task automatic drd(input int i, output logic [31:0] d);
        @(negedge clk); dev_pl_rd = 1; dev_pl_idx = 6'(i);
        @(negedge clk); dev_pl_rd = 0; d = dev_pl_rdata;
    endtask
    task automatic dfin(input logic [15:0] rc, input logic [20:0] ol, input logic bg);
        @(negedge clk); dev_done = 1; dev_rc = rc; dev_out_len = ol; dev_bg = bg;
        @(negedge clk); dev_done = 0; dev_bg = 0;
    endtask
    task automatic dpct(input logic [6:0] p, input logic [15:0] rc);
        @(negedge clk); dev_pct_valid = 1; dev_pct = p; dev_bg_rc = rc;
        @(negedge clk); dev_pct_valid = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        chk("R1 cmd_valid", 64'(dev_cmd_valid), 0);
        chk("R1 irq", 64'(irq_pulse), 0);
        hrd(A_CTRL, rv); chk("R1 ctrl", rv, 0);
        hrd(A_CMD, rv);  chk("R1 cmd", rv, 0);
        hrd(A_STAT, rv); chk("R1 stat", rv, 0);
        dpct(7'd50, 16'h1111);
        hrd(A_BG, rv);   chk("R1 bg idle update", rv, 0);
        // R2: capability
        hrd(A_CAP, rv);  chk("R2 cap", rv, 64'h328);

        // R7: host fill and readback of every word
        for (int i = 0; i < NWORDS; i++) hwr(A_PL + 12'(4 * i), {32'hFFFF_FFFF, pat_h(i)});
        for (int i = 0; i < NWORDS; i++) begin
            hrd(A_PL + 12'(4 * i), rv); chk("R7 host readback", rv, {32'd0, pat_h(i)});
        end
        hrd(A_PL + 12'h100, rv); chk("R7 beyond payload", rv, 0);

        // R3: launch
        hwr(A_CMD, (64'd100 << 16) | 64'h1234);
        hwr(A_CTRL, 64'h1);
        chk("R3 strobe", 64'(dev_cmd_valid), 1);
        chk("R3 opcode", 64'(dev_opcode), 64'h1234);
        chk("R3 len", 64'(dev_in_len), 64'd100);
        @(negedge clk); chk("R3 single pulse", 64'(dev_cmd_valid), 0);

        // R4: busy reads and repeat doorbell
        hrd(A_CTRL, rv); chk("R4 busy bit", rv, 1);
        hwr(A_CTRL, 64'h1);
        @(negedge clk); chk("R4 no relaunch", 64'(launches), 1);

        // R6: host writes while busy are dropped
        hwr(A_CMD, 64'hFFFF);
        hwr(A_PL, 64'hDEAD_BEEF);
        hrd(A_CMD, rv); chk("R6 cmd frozen", rv, (64'd100 << 16) | 64'h1234);

        // R7: device sees host data, then overwrites all words
        for (int i = 0; i < NWORDS; i++) begin
            drd(i, w); chk("R7 device read", 64'(w), 64'(pat_h(i)));
        end
        for (int i = 0; i < NWORDS; i++) dwr(i, pat_d(i));

        // R11 and R5: completion with a colliding doorbell write
        @(negedge clk);
        dev_done = 1; dev_rc = 16'h0000; dev_out_len = 21'd64; dev_bg = 0;
        host_wr = 1; host_addr = A_CTRL; host_wdata = 64'h1;
        @(negedge clk); dev_done = 0; host_wr = 0;
        @(negedge clk); chk("R11 no launch", 64'(launches), 1);
        hrd(A_CTRL, rv); chk("R11 doorbell clear", rv, 0);
        hrd(A_CMD, rv);  chk("R5 out len", rv, (64'd64 << 16) | 64'h1234);
        hrd(A_STAT, rv); chk("R5 rc", rv, 0);
        for (int i = 0; i < NWORDS; i++) begin
            hrd(A_PL + 12'(4 * i), rv); chk("R7 device data", rv, {32'd0, pat_d(i)});
        end

        // R5/R6: idle completion and idle device write are dropped
        dfin(16'h0005, 21'd7, 1'b0);
        hrd(A_STAT, rv); chk("R5 idle done", rv, 0);
        dwr(1, 32'h0BAD_0BAD);
        hrd(A_PL + 12'd4, rv); chk("R6 idle dev write", rv, {32'd0, pat_d(1)});

        // R5: error return code
        hwr(A_CMD, (64'd8 << 16) | 64'h0042);
        hwr(A_CTRL, 64'h1);
        dfin(16'h0017, 21'd0, 1'b0);
        hrd(A_STAT, rv); chk("R5 error rc", rv, 64'h17);
        hrd(A_CMD, rv);  chk("R5 zero len", rv, 64'h0042);

        // R8: background launch with interrupt enabled
        hwr(A_CMD, 64'h4400);
        hwr(A_CTRL, 64'h3);
        dfin(16'h0099, 21'd0, 1'b1);
        hrd(A_STAT, rv); chk("R8 bg code", rv, 64'h1);
        hrd(A_BG, rv);   chk("R8 bg record", rv, 64'h4400);

        // R9: sweep percentages below 100
        for (int p = 0; p < 100; p++) begin
            dpct(7'(p), 16'h0);
            chk("R10 no early irq", 64'(irq_pulse), 0);
            hrd(A_BG, rv); chk("R9 pct", rv, (64'(p) << 16) | 64'h4400);
        end
        // R9/R10: saturating final update
        dpct(7'd120, 16'h0055);
        chk("R10 irq pulse", 64'(irq_pulse), 1);
        @(negedge clk); chk("R10 one cycle", 64'(irq_pulse), 0);
        hrd(A_BG, rv); chk("R9 done", rv, (64'h55 << 32) | (64'd100 << 16) | 64'h4400);
        dpct(7'd30, 16'h0066);
        hrd(A_BG, rv); chk("R9 late ignored", rv, (64'h55 << 32) | (64'd100 << 16) | 64'h4400);

        // R10: interrupt disabled
        hwr(A_CTRL, 64'h0);
        hwr(A_CMD, 64'h0044);
        hwr(A_CTRL, 64'h1);
        dfin(16'h0, 21'd0, 1'b1);
        dpct(7'd100, 16'h0021);
        chk("R10 disabled", 64'(irq_pulse), 0);
        hrd(A_BG, rv); chk("R9 rc latched", rv, (64'h21 << 32) | (64'd100 << 16) | 64'h0044);

        // R10: enable written in the finishing cycle has no effect yet
        hwr(A_CMD, 64'h0077);
        hwr(A_CTRL, 64'h1);
        dfin(16'h0, 21'd0, 1'b1);
        @(negedge clk);
        dev_pct_valid = 1; dev_pct = 7'd100; dev_bg_rc = 16'h7;
        host_wr = 1; host_addr = A_CTRL; host_wdata = 64'h2;
        @(negedge clk); dev_pct_valid = 0; host_wr = 0;
        chk("R10 late enable", 64'(irq_pulse), 0);
        hrd(A_CTRL, rv); chk("R10 enable stored", rv, 64'h2);

        // R10: disable written in the finishing cycle still pulses
        hwr(A_CTRL, 64'h3);
        dfin(16'h0, 21'd0, 1'b1);
        @(negedge clk);
        dev_pct_valid = 1; dev_pct = 7'd100; dev_bg_rc = 16'h8;
        host_wr = 1; host_addr = A_CTRL; host_wdata = 64'h0;
        @(negedge clk); dev_pct_valid = 0; host_wr = 0;
        chk("R10 late disable", 64'(irq_pulse), 1);

        summary();
        $finish;
    end
endmodule